// File: doc/BRIEF.md
# Key-Protected Control Register File

A bank of 106 32-bit control registers. It sits behind a word-addressed read/write port and uses the byte offset of each access. Most of the bank is write-protected. The registers in the protected window accept writes only while the key register holds a 32-bit unlock constant. Some offsets hold values that the bus may only read, and one offset is meant to be written but not read. The block reports every misuse on a single-cycle violation flag: locked window, read-only target, read of the write-only slot, access beyond the bank, or a misaligned or partial access. A misuse never changes the stored state.

The power-on value of every register comes from a companion array of reset values. An integrator fills this array at elaboration with a parameter fill value. It can also change the array at run time through a configuration port, which takes a byte offset and a value. The functional reset copies the array into the live bank. The array itself is cleared only by power-on reset, so a value set through the port survives any number of functional resets.

The bus side is a single-beat request with a valid strobe. It applies no back-pressure: every access completes in the cycle it is presented, so the port has no ready signal and a new access may follow in the very next cycle.

Top module: `keyed_ctrl_bank`

## Requirements
- R1: After power-on and functional reset, every register reads back the parameter fill value, which is 0 by default, and all violation flags are low.
- R2: The key register is at offset 0x000 and is always writable. Writing 0x1688A8A8 to it unlocks the protected window.
- R3: While the key register does not hold 0x1688A8A8, a write to any offset above 0x000 and below 0x104 leaves the register unchanged and pulses `err_lock`.
- R4: A write to offset 0x104 or above, within the bank, is never blocked by the lock state.
- R5: Offsets 0x014, 0x050 to 0x06C, 0x078, 0x07C, 0x0E0 and 0x0E4 are read-only. When the lock does not already reject a write to one of them, the write is discarded and `err_ro` pulses.
- R6: Offset 0x0C0 is write-only. A read of it returns the stored value and pulses `err_wo_rd`.
- R7: An access at a register index of 106 or more, meaning offset 0x1A8 and up, is out of range. A read there returns zero, a write there changes nothing, and `err_oob` pulses.
- R8: An access with address bits [1:0] not equal to 00, or with a byte enable other than 4'b1111, is rejected. A read returns zero, no register changes, and `err_align` pulses. This check takes priority over all the others.
- R9: A configuration write stores a reset value for the register at `cfg_addr`>>2, ignoring indices of 106 and up. It does not affect the live register, it is not subject to the lock, it is loaded by the next functional reset, and it persists across functional resets.
- R10: Read data is valid combinationally in the cycle of the read strobe. Writes commit at the clock edge. A violation flag is high for exactly the one cycle after the edge that sampled the access, and at most one flag is high at a time.
- R11: Writing any value other than 0x1688A8A8 to the key register locks the window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears the reset-value array |
| rst_n | input | 1 | Synchronous functional reset, active low; loads the bank from the array |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 selects a write, 0 selects a read |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_be | input | 4 | Byte enables; must be all ones |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Read data, combinational |
| cfg_we | input | 1 | Reset-value write strobe |
| cfg_addr | input | ADDR_W (12) | Byte offset of the reset value to set |
| cfg_data | input | 32 | Reset value |
| err_align | output | 1 | Misaligned or partial access pulse |
| err_oob | output | 1 | Out-of-range access pulse |
| err_lock | output | 1 | Write blocked by lock pulse |
| err_ro | output | 1 | Write to a read-only offset pulse |
| err_wo_rd | output | 1 | Read of the write-only offset pulse |

## Verification
Read data is due in the same cycle as its strobe. The bench therefore samples `bus_rdata` a quarter period after the falling edge on which the access was driven, before the rising edge that commits it. The violation flags pass through one register, so they are due in the cycle after that rising edge, and the monitor samples them a quarter period after it. In any cycle that follows one with no access, the monitor expects every flag to be low. The effect of a write is observed through a later read, and the effect of a configuration write only after a functional reset. The scoreboard's reference model applies each change at the same point.

// File: rtl/kcb_pkg.sv
package kcb_pkg;
  // One flag per kind of violation; at most one is set per access.
  typedef struct packed {
    logic align;
    logic oob;
    logic lock;
    logic ro;
    logic wo_rd;
  } kcb_err_t;

  // Register indices (byte offset >> 2) whose contents the bus may only read.
  function automatic logic kcb_is_ro(input int unsigned idx);
    return (idx == 5) || (idx >= 20 && idx <= 27) || (idx == 30) ||
           (idx == 31) || (idx == 56) || (idx == 57);
  endfunction
endpackage

// File: rtl/kcb_classify.sv
module kcb_classify
  import kcb_pkg::*;
#(
  parameter int N_REGS    = 106,
  parameter int ADDR_W    = 12,
  parameter int BE_W      = 4,
  parameter int LOCK_END  = 65,   // first index past the protected window
  parameter int WO_IDX    = 48,
  localparam int IDX_W    = $clog2(N_REGS)
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic              key_ok,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_en,
  output logic              rd_en,
  output kcb_err_t          err
);
  localparam int FULL_W = ADDR_W - 2;

  logic [FULL_W-1:0] idx_full;
  logic              aligned, in_range, in_window;

  assign idx_full  = addr[ADDR_W-1:2];
  assign idx       = idx_full[IDX_W-1:0];
  assign aligned   = (addr[1:0] == 2'b00) && (&be);
  assign in_range  = (int'(idx_full) < N_REGS);
  assign in_window = (idx_full != '0) && (int'(idx_full) < LOCK_END);

  always_comb begin
    err   = '0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    if (valid) begin
      if (!aligned) begin
        err.align = 1'b1;
      end else if (!in_range) begin
        err.oob = 1'b1;
      end else if (write) begin
        if (in_window && !key_ok) err.lock = 1'b1;
        else if (kcb_is_ro(int'(idx_full))) err.ro = 1'b1;
        else wr_en = 1'b1;
      end else begin
        rd_en     = 1'b1;
        err.wo_rd = (int'(idx_full) == WO_IDX);
      end
    end
  end
endmodule

// File: rtl/kcb_rstvals.sv
module kcb_rstvals #(
  parameter int          N_REGS = 106,
  parameter int          DATA_W = 32,
  parameter logic [31:0] FILL   = 32'h0,
  localparam int         IDX_W  = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_idx_ok,
  input  logic [DATA_W-1:0] cfg_data,
  output logic [DATA_W-1:0] rv [N_REGS]
);
  // Only power-on reset touches the array; the functional reset reads it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < N_REGS; i++) rv[i] <= FILL[DATA_W-1:0];
    end else if (cfg_we && cfg_idx_ok) begin
      rv[cfg_idx] <= cfg_data;
    end
  end
endmodule

// File: rtl/kcb_bank.sv
module kcb_bank #(
  parameter int          N_REGS  = 106,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] KEY_VAL = 32'h1688A8A8,
  localparam int         IDX_W   = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rv [N_REGS],
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              key_ok
);
  logic [DATA_W-1:0] regs [N_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REGS; i++) regs[i] <= rv[i];
    end else if (wr_en) begin
      regs[idx] <= wdata;
    end
  end

  assign rdata  = rd_en ? regs[idx] : '0;
  assign key_ok = (regs[0] == KEY_VAL[DATA_W-1:0]);
endmodule

// File: rtl/keyed_ctrl_bank.sv
module keyed_ctrl_bank
  import kcb_pkg::*;
#(
  parameter int          N_REGS   = 106,
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] KEY_VAL  = 32'h1688A8A8,
  parameter logic [31:0] RST_FILL = 32'h0,
  parameter int          LOCK_END = 65,
  parameter int          WO_IDX   = 48,
  localparam int         BE_W     = DATA_W / 8,
  localparam int         IDX_W    = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              err_align,
  output logic              err_oob,
  output logic              err_lock,
  output logic              err_ro,
  output logic              err_wo_rd
);
  logic [DATA_W-1:0] rv [N_REGS];
  logic [IDX_W-1:0]  idx;
  logic              wr_en, rd_en, key_ok;
  kcb_err_t          err_d, err_q;
  logic [ADDR_W-3:0] cfg_full;
  logic              cfg_idx_ok;

  assign cfg_full   = cfg_addr[ADDR_W-1:2];
  assign cfg_idx_ok = (int'(cfg_full) < N_REGS);

  kcb_classify #(
    .N_REGS(N_REGS), .ADDR_W(ADDR_W), .BE_W(BE_W),
    .LOCK_END(LOCK_END), .WO_IDX(WO_IDX)
  ) u_classify (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr), .be(bus_be),
    .key_ok(key_ok), .idx(idx), .wr_en(wr_en), .rd_en(rd_en), .err(err_d)
  );

  kcb_rstvals #(.N_REGS(N_REGS), .DATA_W(DATA_W), .FILL(RST_FILL)) u_rstvals (
    .clk(clk), .por_n(por_n), .cfg_we(cfg_we), .cfg_idx(cfg_full[IDX_W-1:0]),
    .cfg_idx_ok(cfg_idx_ok), .cfg_data(cfg_data), .rv(rv)
  );

  kcb_bank #(.N_REGS(N_REGS), .DATA_W(DATA_W), .KEY_VAL(KEY_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n), .rv(rv), .wr_en(wr_en), .rd_en(rd_en),
    .idx(idx), .wdata(bus_wdata), .rdata(bus_rdata), .key_ok(key_ok)
  );

  // Violation flags: one registered pulse per offending access.
  always_ff @(posedge clk) begin
    if (!rst_n || !por_n) err_q <= '0;
    else                  err_q <= err_d;
  end

  assign err_align = err_q.align;
  assign err_oob   = err_q.oob;
  assign err_lock  = err_q.lock;
  assign err_ro    = err_q.ro;
  assign err_wo_rd = err_q.wo_rd;
endmodule

// File: rtl/kcb_checker.sv
module kcb_checker #(
  parameter int          N_REGS  = 106,
  parameter int          ADDR_W  = 12,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] KEY_VAL = 32'h1688A8A8,
  parameter int          LOCK_END = 65,
  localparam int         BE_W    = DATA_W / 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BE_W-1:0]   bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              err_align,
  input logic              err_oob,
  input logic              err_lock,
  input logic              err_ro,
  input logic              err_wo_rd,
  input logic              key_ok
);
  logic       ok_shape;
  logic [4:0] flags;
  int unsigned widx;

  assign ok_shape = (bus_addr[1:0] == 2'b00) && (&bus_be);
  assign flags    = {err_align, err_oob, err_lock, err_ro, err_wo_rd};
  assign widx     = int'(bus_addr[ADDR_W-1:2]);

  a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_valid && bus_write && ok_shape && widx == 0 && bus_wdata == KEY_VAL[DATA_W-1:0])
    |=> key_ok);

  a_r11_relock: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_valid && bus_write && ok_shape && widx == 0 && bus_wdata != KEY_VAL[DATA_W-1:0])
    |=> !key_ok);

  a_r3_locked_write: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_valid && bus_write && ok_shape && widx > 0 && widx < LOCK_END && !key_ok)
    |=> err_lock);

  a_r4_high_unblocked: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_valid && bus_write && ok_shape && widx >= LOCK_END && widx < N_REGS)
    |=> !err_lock && !err_oob);

  a_r7_oob_zero: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_valid && !bus_write && ok_shape && widx >= N_REGS) |-> bus_rdata == '0);

  a_r8_align: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_valid && !ok_shape) |=> err_align);

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $onehot0(flags));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !bus_valid |=> flags == 5'b0);
endmodule

bind keyed_ctrl_bank kcb_checker #(
  .N_REGS(N_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .KEY_VAL(KEY_VAL), .LOCK_END(LOCK_END)
) u_kcb_checker (.*);

// File: tb/test_keyed_ctrl_bank.sv
module test_keyed_ctrl_bank;
  localparam int          CLK_P = 10;
  localparam int          N     = 106;
  localparam logic [31:0] KEY   = 32'h1688A8A8;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic        err_align, err_oob, err_lock, err_ro, err_wo_rd;

  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] rd;
    bit          chk_rd;
    logic [4:0]  err;   // {align, oob, lock, ro, wo_rd}
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [31:0] mdl [N];
  logic [31:0] rv  [N];

  always #(CLK_P/2) clk = ~clk;

  keyed_ctrl_bank i_keyed_ctrl_bank (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .err_align(err_align), .err_oob(err_oob), .err_lock(err_lock),
    .err_ro(err_ro), .err_wo_rd(err_wo_rd)
  );

  function automatic bit ro_idx(int i);
    return i == 5 || (i >= 20 && i <= 27) || i == 30 || i == 31 || i == 56 || i == 57;
  endfunction

  // Driver: computes the expected outcome from the requirements and queues it.
  task automatic acc(bit w, logic [11:0] a, logic [3:0] be, logic [31:0] d, string tag);
    exp_t e;
    int   i;
    e.rd = '0; e.chk_rd = !w; e.err = 5'b0; e.tag = tag;
    i = int'(a[11:2]);
    if (a[1:0] != 2'b00 || be != 4'hF) e.err = 5'b10000;
    else if (i >= N) e.err = 5'b01000;
    else if (w) begin
      if (i > 0 && i < 65 && mdl[0] != KEY) e.err = 5'b00100;
      else if (ro_idx(i)) e.err = 5'b00010;
      else mdl[i] = d;
    end else begin
      e.rd = mdl[i];
      if (i == 48) e.err = 5'b00001;
    end
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_be = be; bus_wdata = d;
    q.push_back(e);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    acc(1'b1, a, 4'hF, d, tag);
  endtask

  task automatic rd(logic [11:0] a, string tag);
    acc(1'b0, a, 4'hF, 32'h0, tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_valid = 1'b0;
    end
  endtask

  task automatic cfg(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b0; cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    if (int'(a[11:2]) < N) rv[int'(a[11:2])] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic func_reset();
    @(negedge clk);
    bus_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < N; k++) mdl[k] = rv[k];
  endtask

  // Monitor: rdata due before the committing edge, flags due one cycle after it.
  initial begin
    logic [31:0] got_rd;
    bit          pend;
    exp_t        e;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      pend = bus_valid;
      got_rd = bus_rdata;
      @(posedge clk);
      #(CLK_P/4);
      if (pend) begin
        e = q.pop_front();
        if (e.chk_rd) begin
          tests++;
          if (got_rd !== e.rd) begin
            fails++;
            $display("FAIL %s rdata: actual %h expected %h", e.tag, got_rd, e.rd);
          end
        end
        tests++;
        if ({err_align, err_oob, err_lock, err_ro, err_wo_rd} !== e.err) begin
          fails++;
          $display("FAIL %s flags: actual %b expected %b", e.tag,
                   {err_align, err_oob, err_lock, err_ro, err_wo_rd}, e.err);
        end
      end else if (por_n && rst_n) begin
        tests++;
        if ({err_align, err_oob, err_lock, err_ro, err_wo_rd} !== 5'b0) begin
          fails++;
          $display("FAIL R10 idle flags: actual %b expected 00000",
                   {err_align, err_oob, err_lock, err_ro, err_wo_rd});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin rv[k] = 32'h0; mdl[k] = 32'h0; end
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1: reset contents
    rd(12'h000, "R1 key reset");
    rd(12'h1A4, "R1 last reg reset");
    rd(12'h030, "R1 mid reg reset");
    // R3: locked window
    wr(12'h008, 32'h0000_00A5, "R3 locked write");
    rd(12'h008, "R3 locked value kept");
    wr(12'h100, 32'h1, "R3 window top locked");
    // R4: above window
    wr(12'h104, 32'h0000_1234, "R4 write 0x104");
    rd(12'h104, "R4 readback 0x104");
    wr(12'h1A4, 32'h0000_FEED, "R4 write last");
    rd(12'h1A4, "R4 readback last");
    // R2: unlock
    wr(12'h000, KEY, "R2 unlock");
    rd(12'h000, "R2 key readback");
    wr(12'h008, 32'h0000_00A5, "R2 unlocked write");
    rd(12'h008, "R2 unlocked readback");
    // R5: read-only offsets
    wr(12'h014, 32'hDEAD_0001, "R5 ro 0x014");
    wr(12'h060, 32'hDEAD_0002, "R5 ro 0x060");
    wr(12'h0E4, 32'hDEAD_0003, "R5 ro 0x0E4");
    rd(12'h014, "R5 ro kept 0x014");
    rd(12'h060, "R5 ro kept 0x060");
    rd(12'h0E4, "R5 ro kept 0x0E4");
    // R6: write-only slot
    wr(12'h0C0, 32'h0000_0077, "R6 wo write");
    rd(12'h0C0, "R6 wo read");
    // R7: out of range
    rd(12'h1A8, "R7 oob read");
    wr(12'h1A8, 32'h5555_5555, "R7 oob write");
    rd(12'hFFC, "R7 far oob read");
    // R8: alignment
    acc(1'b1, 12'h00D, 4'hF, 32'h1111_1111, "R8 misaligned write");
    acc(1'b1, 12'h00C, 4'h7, 32'h2222_2222, "R8 partial write");
    acc(1'b0, 12'h00A, 4'hF, 32'h0, "R8 misaligned read");
    acc(1'b0, 12'h1A9, 4'hF, 32'h0, "R8 precedence over oob");
    rd(12'h00C, "R8 no change");
    // R10: back-to-back writes then read
    wr(12'h040, 32'h0BAD_F00D, "R10 back2back w");
    rd(12'h040, "R10 back2back r");
    // R11: relock
    wr(12'h000, 32'h0, "R11 relock");
    wr(12'h00C, 32'h3333_3333, "R11 locked again");
    rd(12'h00C, "R11 value kept");
    idle(2);
    // R9: configuration port
    cfg(12'h00C, 32'h0000_CAFE);
    cfg(12'h000, KEY);
    cfg(12'h1A8, 32'h9999_9999);
    rd(12'h00C, "R9 cfg not live");
    idle(1);
    func_reset();
    rd(12'h00C, "R9 cfg loaded");
    rd(12'h000, "R9 key from cfg");
    rd(12'h008, "R9 old write cleared");
    rd(12'h104, "R9 high reg cleared");
    wr(12'h010, 32'h5, "R9 unlocked by cfg");
    rd(12'h010, "R9 readback");
    idle(1);
    func_reset();
    rd(12'h00C, "R9 array persists");
    rd(12'h010, "R1 reloaded fill");
    idle(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule